// File: doc/BRIEF.md
# T1 Data Link Byte Serializer

This block feeds the facility data link bit positions of an outgoing T1 stream from a byte that the host writes. The frame timing logic outside the block pulses `slot_stb` for one clock at every position that carries a data link bit in ESF or an Fs bit in D4. While the strobe is high, the block presents on `fdl_bit` the bit to insert. It does not count frames, build the line stream, stuff zeros or add HDLC framing.

The host writes a byte into a holding register. That byte is copied into the shift register at the first strobe of each byte period, so a write made in the middle of a byte does not disturb the byte being sent. When a byte ends, a latched empty flag asks for new data. If the host writes nothing new, the last byte is sent again. In D4 mode a byte period is six strobes long, which lets the same register produce the Fs framing pattern. A source-select input can take the register off the line.

Top module: `fdl_byte_tx`

## Requirements
- R1: On each strobe, `fdl_bit` carries one bit of the current byte, starting with bit 0 and rising by one bit per strobe. No bits are inserted or altered, so a byte of FFh produces eight consecutive ones.
- R2: `empty_flag` is 0 after reset. It becomes 1 in the cycle after the strobe that sends the final bit of a byte (bit 7 in ESF mode), and not earlier in the byte.
- R3: `irq_n` is 0 exactly when `empty_flag` is 1 and `irq_en` is 1. Otherwise it is 1, including after reset.
- R4: A cycle with `sts_wr`=1 and `sts_wr_data`=1 clears `empty_flag`. With `sts_wr_data`=0 the flag does not change.
- R5: When no byte is written during a byte period, the next byte period sends the same byte again unchanged.
- R6: A byte written while a byte is being sent does not change the rest of that byte. The new byte is sent from the first strobe of the next byte period.
- R7: With `mode_d4`=1, a byte period is six strobes and sends bits 0 to 5. The empty flag sets after bit 5. Writing 1Ch produces the sequence 0,0,1,1,1,0 on every period.
- R8: While `src_other`=1, `fdl_bit` is 1 and the empty flag is not set by strobes. Each strobe in this state returns the bit position to 0, so sending restarts at bit 0 once `src_other` returns to 0.
- R9: When a byte completes in the same cycle as a clear request, `empty_flag` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_stb | input | 1 | One-cycle pulse at each data link / Fs bit position |
| src_other | input | 1 | 0 = insert bits from this register, 1 = register deselected |
| mode_d4 | input | 1 | 1 = D4 (six bits per period), 0 = ESF (eight bits) |
| wr_en | input | 1 | Host write strobe for the data byte |
| wr_data | input | 8 | Data byte written by the host |
| sts_wr | input | 1 | Host write strobe for the status flag |
| sts_wr_data | input | 1 | Write-one-to-clear value for the empty flag |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| fdl_bit | output | 1 | Bit to insert at the current strobe |
| empty_flag | output | 1 | Latched byte-complete flag |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Two cases are hard to reach from the ports. The first is a clear request that arrives in the same cycle as the strobe that completes a byte. The bench reaches it by raising `sts_wr` together with the final strobe of a period. The second is a host write that lands in the middle of a byte. The bench writes after a few strobes and then checks that the rest of the old byte goes out before the new byte starts. A scoreboard model tracks the bit position and byte boundaries independently of the design, including positions reset by deselection and changes of mode.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int BYTE_W = 8;
  localparam int D4_W   = 6;
  localparam int IDX_W  = $clog2(BYTE_W);
  typedef logic [IDX_W-1:0] idx_t;

  // last bit position of a byte period for the selected framing mode
  function automatic idx_t fdl_last_idx(input logic d4);
    return d4 ? idx_t'(D4_W - 1) : idx_t'(BYTE_W - 1);
  endfunction

  // bit position after a strobe; wraps to 0 at or past the last position
  function automatic idx_t fdl_next_idx(input idx_t cur, input logic d4);
    return (cur >= fdl_last_idx(d4)) ? idx_t'(0) : idx_t'(cur + 1'b1);
  endfunction
endpackage

// File: rtl/fdl_hold_reg.sv
module fdl_hold_reg #(
  parameter int W = fdl_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= wr_data;
  end
endmodule

// File: rtl/fdl_shifter.sv
module fdl_shifter
  import fdl_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_stb,
  input  logic         src_other,
  input  logic         mode_d4,
  input  logic [W-1:0] hold_q,
  output logic         fdl_bit,
  output logic         cmp_evt
);
  logic [W-1:0] shf_q;
  idx_t         idx_q;
  logic         at_start;
  logic         live_stb;

  assign at_start = (idx_q == '0);
  assign live_stb = slot_stb && !src_other;
  assign cmp_evt  = live_stb && (idx_q >= fdl_last_idx(mode_d4));
  assign fdl_bit  = src_other ? 1'b1 : (at_start ? hold_q[0] : shf_q[idx_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
      idx_q <= '0;
    end else if (slot_stb) begin
      if (src_other) begin
        idx_q <= '0;
      end else begin
        if (at_start) shf_q <= hold_q;
        idx_q <= fdl_next_idx(idx_q, mode_d4);
      end
    end
  end

  // R8
  deselect_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && src_other) |=> (idx_q == '0));
  // R7
  d4_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_stb && mode_d4 && idx_q == idx_t'(D4_W - 1)) |=> (idx_q == '0));
  // R6
  byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_stb && at_start) |=> $stable(shf_q));
endmodule

// File: rtl/fdl_status.sv
module fdl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic empty_q,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       empty_q <= 1'b0;
    else if (cmp_evt) empty_q <= 1'b1;
    else if (clr_req) empty_q <= 1'b0;
  end

  assign irq_n = !(empty_q && irq_en);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> empty_q);
  // R2
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_q) |-> $past(cmp_evt));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !cmp_evt) |=> !empty_q);
endmodule

// File: rtl/fdl_byte_tx.sv
module fdl_byte_tx
  import fdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic              src_other,
  input  logic              mode_d4,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sts_wr,
  input  logic              sts_wr_data,
  input  logic              irq_en,
  output logic              fdl_bit,
  output logic              empty_flag,
  output logic              irq_n
);
  logic [BYTE_W-1:0] hold_q;
  logic              cmp_evt;
  logic              clr_req;

  assign clr_req = sts_wr && sts_wr_data;

  fdl_hold_reg #(.W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .hold_q(hold_q)
  );

  fdl_shifter #(.W(BYTE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .src_other(src_other),
    .mode_d4(mode_d4), .hold_q(hold_q), .fdl_bit(fdl_bit), .cmp_evt(cmp_evt)
  );

  fdl_status u_sts (
    .clk(clk), .rst_n(rst_n), .cmp_evt(cmp_evt), .clr_req(clr_req),
    .irq_en(irq_en), .empty_q(empty_flag), .irq_n(irq_n)
  );

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n) |-> (empty_flag && irq_en));
  // R8
  deselect_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_other |-> fdl_bit);
endmodule

// File: tb/tb_fdl_byte_tx.sv
module tb_fdl_byte_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_stb = 0, src_other = 0, mode_d4 = 0, wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic sts_wr = 0, sts_wr_data = 0, irq_en = 0;
  logic fdl_bit, empty_flag, irq_n;

  int checks = 0, failures = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];

  logic [7:0] m_hold = 8'h00, m_byte = 8'h00;
  int         m_idx = 0;
  logic       m_empty = 0;

  always #10 clk = ~clk;

  fdl_byte_tx dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .src_other(src_other),
    .mode_d4(mode_d4), .wr_en(wr_en), .wr_data(wr_data), .sts_wr(sts_wr),
    .sts_wr_data(sts_wr_data), .irq_en(irq_en), .fdl_bit(fdl_bit),
    .empty_flag(empty_flag), .irq_n(irq_n)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: compare each strobe's output bit against the scoreboard
  always @(negedge clk) begin
    if (slot_stb) begin
      if (exp_q.size() == 0) chk("R1 queue empty", 1, 0);
      else chk(tag_q.pop_front(), {31'd0, fdl_bit}, {31'd0, exp_q.pop_front()});
    end
  end

  task automatic write_byte(input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; wr_data = d; m_hold = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic clear_sts(input logic v);
    @(posedge clk); #1 sts_wr = 1; sts_wr_data = v;
    @(posedge clk); #1 sts_wr = 0;
    if (v) m_empty = 0;
  endtask

  // driver: model the strobe, push the expected bit, then pulse it
  task automatic slot(input string r, input logic clr = 0);
    logic e;
    int   last;
    bit   cmp = 0;
    @(posedge clk); #1;
    if (src_other) begin
      e = 1'b1; m_idx = 0;
    end else begin
      if (m_idx == 0) m_byte = m_hold;
      e = m_byte[m_idx];
      last = mode_d4 ? 5 : 7;
      if (m_idx >= last) begin m_idx = 0; cmp = 1; end
      else m_idx++;
    end
    exp_q.push_back(e); tag_q.push_back(r);
    slot_stb = 1; sts_wr = clr; sts_wr_data = clr;
    @(posedge clk); #1 slot_stb = 0; sts_wr = 0;
    if (cmp) m_empty = 1; else if (clr) m_empty = 0;
  endtask

  task automatic chk_sts(input string r);
    chk({r, " empty"}, {31'd0, empty_flag}, {31'd0, m_empty});
    chk({r, " irq"}, {31'd0, irq_n}, {31'd0, !(m_empty && irq_en)});
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R2 reset empty", {31'd0, empty_flag}, 0);
    chk("R3 reset irq", {31'd0, irq_n}, 1);
    chk("R1 reset bit", {31'd0, fdl_bit}, 0);

    // R1 / R2: ESF byte, LSB first; flag only after bit 7
    write_byte(8'hA5);
    for (int i = 0; i < 7; i++) slot("R1 esf A5");
    chk_sts("R2 before last");
    slot("R1 esf A5");
    chk_sts("R2 after last");
    // R3: mask
    irq_en = 1; #1 chk_sts("R3 masked on");
    irq_en = 0; #1 chk_sts("R3 masked off");
    irq_en = 1;
    // R4: write zero has no effect, write one clears
    clear_sts(0); chk_sts("R4 zero write");
    clear_sts(1); chk_sts("R4 one write");
    // R5: repeat without new write
    for (int i = 0; i < 8; i++) slot("R5 repeat A5");
    chk_sts("R5 set again");
    clear_sts(1);
    // R1: all ones, no stuffing
    write_byte(8'hFF);
    for (int i = 0; i < 8; i++) slot("R1 ones");
    clear_sts(1);
    // R6: mid-byte write
    write_byte(8'h96);
    for (int i = 0; i < 3; i++) slot("R6 old byte");
    write_byte(8'h3C);
    for (int i = 0; i < 5; i++) slot("R6 old byte tail");
    for (int i = 0; i < 8; i++) slot("R6 new byte");
    // R9: clear coinciding with completion
    clear_sts(1);
    for (int i = 0; i < 7; i++) slot("R9 bits");
    slot("R9 bits", 1'b1);
    chk_sts("R9 set wins");
    clear_sts(1);
    // R7: D4 Fs pattern
    mode_d4 = 1;
    write_byte(8'h1C);
    for (int i = 0; i < 5; i++) slot("R7 d4 Fs");
    chk_sts("R7 before bit5");
    slot("R7 d4 Fs");
    chk_sts("R7 after bit5");
    for (int i = 0; i < 6; i++) slot("R7 d4 Fs repeat");
    clear_sts(1);
    // R8: deselect mid-byte, restart at bit 0
    mode_d4 = 0;
    write_byte(8'hE1);
    for (int i = 0; i < 3; i++) slot("R8 pre");
    src_other = 1;
    for (int i = 0; i < 10; i++) slot("R8 held one");
    chk_sts("R8 no completion");
    src_other = 0;
    for (int i = 0; i < 8; i++) slot("R8 restart");
    chk_sts("R8 restart done");

    repeat (3) @(posedge clk);
    chk("R1 queue drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule